// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Token Unit

This block keeps eight hardware lock flags that two independent agents, a left port and a right port, share. Each port picks a flag with a 3-bit index. A port asks for a flag by writing a 0 and gives it back by writing a 1. A read shows that port's own view of the flag. The view is 0 while the port holds the token and 1 otherwise, and the value appears on every bit of a 9-bit read bus.

A request from the side that does not hold the token does not fail. The block records it as pending. When the holder gives the flag back, the token goes straight to the waiting side, so no retry or polling loop is needed. A waiting port can withdraw its request by writing a 1. When both ports ask for the same free flag in the same clock, the left port wins and the right port's request is recorded as pending.

Writes take effect at the rising clock edge. The read bus is a combinational view of the registered state at the currently presented index.

Top module: `sem_token_unit`

## Requirements
- R1: After a synchronous active-low reset all eight flags are free and no request is pending.
- R2: A flag is changed only by a semaphore write: chip enable high, semaphore select low and write strobe high, all in the same cycle. A write with any of these three signals inactive changes nothing.
- R3: The 3-bit index selects one of eight flags. A write to one index never changes the state of any other index.
- R4: A write uses only the single data-in bit. A read shows the flag on all nine read bits: 9'h000 when this port holds the token and 9'h1FF otherwise.
- R5: A free flag reads 9'h1FF on both ports.
- R6: A port that writes 0 to a free flag takes the token and reads 9'h000 from the next cycle on. The other port reads 9'h1FF. Both ports never read 0 at the same index.
- R7: While one port holds a flag, a 0 written by the other port does not change ownership. That port keeps reading 9'h1FF, and its request is recorded as pending.
- R8: When the holder writes 1 while the other port's request is pending, the token passes directly to the waiting port in the same edge.
- R9: When the holder writes 1 and no request is pending, the flag becomes free.
- R10: A pending request is cancelled when the requesting port writes 1 before it is granted. A later release by the holder then frees the flag.
- R11: When both ports write 0 to the same free flag in one cycle, the left port takes the token and the right port's request is recorded as pending.
- R12: Over any interleaving of accesses from both ports, each port's reading follows R4 to R11. A holder writing 0 again, or a non-holder writing 1 with nothing pending, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lt_ce | input | 1 | Left chip enable, active high |
| lt_sel_n | input | 1 | Left semaphore select, active low |
| lt_idx | input | 3 | Left flag index |
| lt_wr | input | 1 | Left write strobe, active high |
| lt_din | input | 1 | Left write data: 0 requests, 1 releases |
| lt_dout | output | 9 | Left view of the indexed flag, replicated |
| rt_ce | input | 1 | Right chip enable, active high |
| rt_sel_n | input | 1 | Right semaphore select, active low |
| rt_idx | input | 3 | Right flag index |
| rt_wr | input | 1 | Right write strobe, active high |
| rt_din | input | 1 | Right write data: 0 requests, 1 releases |
| rt_dout | output | 9 | Right view of the indexed flag, replicated |

## Verification
The state that is hardest to reach from the ports is a pending request that meets a same-cycle event from the other side. Examples are a release by the holder in the very cycle the waiter withdraws, and a tie on a free flag followed by a handover. These cases are invisible at the ports until a later release shows who holds the token. Directed sequences build each of these orderings on chosen indices. After them comes a long pseudo-random sweep that steers both ports onto a few shared indices so that collisions are frequent. After every edge the sweep compares both read buses against an ownership model kept in the bench.

// File: rtl/sem_pkg.sv
// Shared types for the semaphore token unit.
// Assumes: exactly two requesters, called left and right.
package sem_pkg;
    typedef enum logic [1:0] {
        SEM_FREE  = 2'd0,
        SEM_LEFT  = 2'd1,
        SEM_RIGHT = 2'd2
    } sem_owner_t;
endpackage

// File: rtl/sem_port_decode.sv
// Turns one port's access pins into one-hot request and release strobes,
// one pair per flag.
// Assumes: a write needs ce high, sel_n low and wr high in the same cycle.
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic               ce,
    input  logic               sel_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wr,
    input  logic               din,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel
);
    logic wr_hit;

    // qualify the write strobe with both select pins
    always_comb wr_hit = ce && !sel_n && wr;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        // steer the strobe to the addressed flag only
        always_comb begin
            req[g] = wr_hit && (idx == IDX_W'(g)) && !din;
            rel[g] = wr_hit && (idx == IDX_W'(g)) &&  din;
        end
    end
endmodule

// File: rtl/sem_cell.sv
// One semaphore flag: records the holder and at most one pending request
// from the side that does not hold it.
// Assumes: req and rel from the same side are never high together.
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_own,
    output logic r_own
);
    sem_owner_t own_q, own_d;
    logic lp_q, lp_d, rp_q, rp_d;
    logic l_wait, r_wait;

    // a side is waiting after this edge if it asked now or before and has not withdrawn
    always_comb begin
        l_wait = (lp_q || l_req) && !l_rel;
        r_wait = (rp_q || r_req) && !r_rel;
    end

    // next-state rules for ownership and the pending marks
    always_comb begin
        own_d = own_q;
        lp_d  = lp_q;
        rp_d  = rp_q;
        case (own_q)
            SEM_FREE: begin
                lp_d = 1'b0;
                rp_d = 1'b0;
                if (l_req) begin
                    own_d = SEM_LEFT;
                    rp_d  = r_req;
                end else if (r_req) begin
                    own_d = SEM_RIGHT;
                end
            end
            SEM_LEFT: begin
                lp_d = 1'b0;
                if (l_rel) begin
                    own_d = r_wait ? SEM_RIGHT : SEM_FREE;
                    rp_d  = 1'b0;
                end else begin
                    rp_d = r_wait;
                end
            end
            SEM_RIGHT: begin
                rp_d = 1'b0;
                if (r_rel) begin
                    own_d = l_wait ? SEM_LEFT : SEM_FREE;
                    lp_d  = 1'b0;
                end else begin
                    lp_d = l_wait;
                end
            end
            default: begin
                own_d = SEM_FREE;
                lp_d  = 1'b0;
                rp_d  = 1'b0;
            end
        endcase
    end

    // state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= SEM_FREE;
            lp_q  <= 1'b0;
            rp_q  <= 1'b0;
        end else begin
            own_q <= own_d;
            lp_q  <= lp_d;
            rp_q  <= rp_d;
        end
    end

    // expose per-side holder flags
    always_comb begin
        l_own = (own_q == SEM_LEFT);
        r_own = (own_q == SEM_RIGHT);
    end

    AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_q && rp_q)); // R7
    AST_LPEND_NEEDS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        lp_q |-> own_q == SEM_RIGHT); // R7
    AST_RPEND_NEEDS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        rp_q |-> own_q == SEM_LEFT); // R7
    AST_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == SEM_LEFT && !l_rel) |=> own_q == SEM_LEFT); // R7
    AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == SEM_LEFT && rp_q && l_rel && !r_rel) |=> (own_q == SEM_RIGHT && !lp_q)); // R8
    AST_FREE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == SEM_RIGHT && !lp_q && !l_req && r_rel) |=> own_q == SEM_FREE); // R9
    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == SEM_LEFT && !l_rel && r_rel) |=> !rp_q); // R10
    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == SEM_FREE && l_req && r_req) |=> (own_q == SEM_LEFT && rp_q)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_req && !l_rel && !r_req && !r_rel) |=> $stable(own_q)); // R2
endmodule

// File: rtl/sem_read_view.sv
// Selects one port's holder bit at the presented index and spreads it
// over the read bus: all zeros when held by this port, all ones otherwise.
// Assumes: the index is in range for NUM_SEM flags.
module sem_read_view #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 9,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic [NUM_SEM-1:0] own_vec,
    input  logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  dout
);
    // replicate the inverted holder bit across the bus
    always_comb dout = {DATA_W{!own_vec[idx]}};
endmodule

// File: rtl/sem_token_unit.sv
// Top of the dual-port semaphore unit: decodes both ports, keeps NUM_SEM
// token cells and drives each port's read view.
// Assumes: both ports share one clock. Writes land at the rising edge,
// and reads are combinational on the registered state.
module sem_token_unit #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 9,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_ce,
    input  logic              lt_sel_n,
    input  logic [IDX_W-1:0]  lt_idx,
    input  logic              lt_wr,
    input  logic              lt_din,
    output logic [DATA_W-1:0] lt_dout,
    input  logic              rt_ce,
    input  logic              rt_sel_n,
    input  logic [IDX_W-1:0]  rt_idx,
    input  logic              rt_wr,
    input  logic              rt_din,
    output logic [DATA_W-1:0] rt_dout
);
    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_SEM-1:0] l_own, r_own;

    sem_port_decode #(.NUM_SEM(NUM_SEM)) u_ldec (
        .ce(lt_ce), .sel_n(lt_sel_n), .idx(lt_idx), .wr(lt_wr), .din(lt_din),
        .req(l_req), .rel(l_rel)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM)) u_rdec (
        .ce(rt_ce), .sel_n(rt_sel_n), .idx(rt_idx), .wr(rt_wr), .din(rt_din),
        .req(r_req), .rel(r_rel)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .l_own(l_own[g]), .r_own(r_own[g])
        );
    end

    sem_read_view #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_lview (
        .own_vec(l_own), .idx(lt_idx), .dout(lt_dout)
    );

    sem_read_view #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rview (
        .own_vec(r_own), .idx(rt_idx), .dout(rt_dout)
    );

    AST_LT_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lt_dout) == 0) || ($countones(lt_dout) == DATA_W)); // R4
    AST_RT_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rt_dout) == 0) || ($countones(rt_dout) == DATA_W)); // R4
    AST_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_idx == rt_idx) |-> !(lt_dout == '0 && rt_dout == '0)); // R6
    AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own & r_own) == '0); // R6
    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(lt_ce && !lt_sel_n && lt_wr) && !(rt_ce && !rt_sel_n && rt_wr))
            |=> ($stable(l_own) && $stable(r_own))); // R2
endmodule

// File: tb/sem_token_unit_test.sv
`timescale 1ns/1ps
module sem_token_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lt_ce = 1'b0, lt_sel_n = 1'b1, lt_wr = 1'b0, lt_din = 1'b1;
    logic rt_ce = 1'b0, rt_sel_n = 1'b1, rt_wr = 1'b0, rt_din = 1'b1;
    logic [2:0] lt_idx = '0, rt_idx = '0;
    logic [8:0] lt_dout, rt_dout;

    int n_chk = 0;
    int n_fail = 0;

    // bench ownership model: 0 free, 1 left, 2 right
    int  m_own [8];
    bit  m_lp  [8];
    bit  m_rp  [8];

    always #2.5 clk = ~clk;

    sem_token_unit uut (
        .clk(clk), .rst_n(rst_n),
        .lt_ce(lt_ce), .lt_sel_n(lt_sel_n), .lt_idx(lt_idx), .lt_wr(lt_wr),
        .lt_din(lt_din), .lt_dout(lt_dout),
        .rt_ce(rt_ce), .rt_sel_n(rt_sel_n), .rt_idx(rt_idx), .rt_wr(rt_wr),
        .rt_din(rt_din), .rt_dout(rt_dout)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] view(input int own, input int side);
        return (own == side) ? 9'h000 : 9'h1FF;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_own[k] = 0; m_lp[k] = 0; m_rp[k] = 0;
        end
    endtask

    // apply one edge of the rules to the model
    task automatic model_step(input bit lw, input bit ld, input int la,
                              input bit rw, input bit rd, input int ra);
        for (int k = 0; k < 8; k++) begin
            bit lq = lw && la == k && !ld;
            bit lr = lw && la == k &&  ld;
            bit rq = rw && ra == k && !rd;
            bit rr = rw && ra == k &&  rd;
            bit lwt = (m_lp[k] || lq) && !lr;
            bit rwt = (m_rp[k] || rq) && !rr;
            if (m_own[k] == 0) begin
                if (lq) begin m_own[k] = 1; m_rp[k] = rq; end
                else if (rq) m_own[k] = 2;
            end else if (m_own[k] == 1) begin
                if (lr) begin m_own[k] = rwt ? 2 : 0; m_rp[k] = 0; end
                else m_rp[k] = rwt;
            end else begin
                if (rr) begin m_own[k] = lwt ? 1 : 0; m_lp[k] = 0; end
                else m_lp[k] = lwt;
            end
        end
    endtask

    // drive one cycle, update model, compare both ports after the edge
    task automatic step(input string tag,
                        input logic lce, input logic lsn, input logic [2:0] la,
                        input logic lw, input logic ld,
                        input logic rce, input logic rsn, input logic [2:0] ra,
                        input logic rw, input logic rd);
        @(negedge clk);
        lt_ce = lce; lt_sel_n = lsn; lt_idx = la; lt_wr = lw; lt_din = ld;
        rt_ce = rce; rt_sel_n = rsn; rt_idx = ra; rt_wr = rw; rt_din = rd;
        @(posedge clk);
        model_step(lce && !lsn && lw, ld, int'(la), rce && !rsn && rw, rd, int'(ra));
        #1;
        chk(tag, lt_dout, view(m_own[la], 1));
        chk(tag, rt_dout, view(m_own[ra], 2));
    endtask

    // read every index on both ports without writing
    task automatic sweep(input string tag);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            lt_wr = 1'b0; rt_wr = 1'b0;
            lt_idx = 3'(k); rt_idx = 3'(k);
            #1;
            chk(tag, lt_dout, view(m_own[k], 1));
            chk(tag, rt_dout, view(m_own[k], 2));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] s;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        sweep("R1 R5 reset all free");

        // R6: left takes flag 3
        step("R6 take", 1,0,3'd3,1,0, 0,1,3'd3,0,1);
        sweep("R3 only flag 3 held");
        // R2: right writes 0 to flag 5 with ce low, sel high, wr low
        step("R2 ce low", 1,0,3'd0,0,1, 0,0,3'd5,1,0);
        step("R2 sel high", 1,0,3'd0,0,1, 1,1,3'd5,1,0);
        step("R2 wr low", 1,0,3'd0,0,1, 1,0,3'd5,0,0);
        sweep("R2 nothing changed");
        // R7: right asks for held flag 3
        step("R7 blocked", 0,1,3'd3,0,1, 1,0,3'd3,1,0);
        step("R12 holder rewrites 0", 1,0,3'd3,1,0, 0,1,3'd3,0,1);
        // R8: left releases, right waiting
        step("R8 handover", 1,0,3'd3,1,1, 0,1,3'd3,0,1);
        chk("R8 right holds", rt_dout, 9'h000);
        chk("R4 left all ones", lt_dout, 9'h1FF);
        // R10: left waits, withdraws, right releases -> free
        step("R10 left waits", 1,0,3'd3,1,0, 0,1,3'd3,0,1);
        step("R10 left withdraws", 1,0,3'd3,1,1, 0,1,3'd3,0,1);
        step("R9 release to free", 0,1,3'd3,0,1, 1,0,3'd3,1,1);
        chk("R9 free left", lt_dout, 9'h1FF);
        chk("R9 free right", rt_dout, 9'h1FF);
        // R11: tie on flag 6
        step("R11 tie", 1,0,3'd6,1,0, 1,0,3'd6,1,0);
        chk("R11 left wins", lt_dout, 9'h000);
        step("R11 pending granted", 1,0,3'd6,1,1, 0,1,3'd6,0,1);
        chk("R11 right got it", rt_dout, 9'h000);
        // R10 same-edge: waiter withdraws as holder releases
        step("R10 left waits on 6", 1,0,3'd6,1,0, 0,1,3'd6,0,1);
        step("R10 simultaneous", 1,0,3'd6,1,1, 1,0,3'd6,1,1);
        chk("R10 simultaneous free", lt_dout, 9'h1FF);
        // R3: all eight held by alternating sides
        for (int k = 0; k < 8; k++)
            step("R3 fill", 1,0,3'(k),k[0]==0,0, 1,0,3'(k),k[0]==1,0);
        sweep("R3 independent flags");
        // R12: random interleavings on mostly shared indices
        s = 32'h1234_5678;
        for (int i = 0; i < 5000; i++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            step("R12 random",
                 s[0] | s[1], s[2] & s[3], {s[7] & s[8], s[5:4]}, s[9] | s[10], s[11],
                 s[12] | s[13], s[14] & s[15], {s[19] & s[20], s[17:16]}, s[21] | s[22], s[23]);
        end
        sweep("R12 final state");
        // R1: reset again in the middle of activity
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk) rst_n = 1'b1;
        sweep("R1 reset clears");
        finish_run();
    end
endmodule